// File: doc/BRIEF.md
# Increment-Only Counter Word Guard

This block guards a small protected region at the bottom of a serial memory's address space: the lowest 32 bytes, arranged as 16 words of 16 bits each. Each word behaves as a counter that may only move upward. The command front end passes the decoded opcode and start address for every command. It then passes each data byte as it arrives, together with a select flag that tracks chip select. When the opcode is the secure write code, the guard arms and takes the next two bytes as a new word value, high byte first. On the clock edge that captures the second byte, it compares that value with the stored word.

The new value is stored only when it is strictly greater, as an unsigned number, than the stored one. A one-cycle accepted or rejected pulse reports the outcome. No other protection setting can override this rule: the comparator alone decides. Storage is a register file that clears to zero on reset. A separate read index gives combinational readback of any word.

Top module: `incr_word_guard`

## Requirements
- R1: After reset every one of the 16 words reads 0x0000, and both `wr_accepted` and `wr_rejected` are low.
- R2: A secure write (opcode 0x07) whose new value is unsigned-greater than the stored word stores it. `wr_accepted` is high for exactly one cycle, starting after the clock edge that captures the second data byte.
- R3: A secure write whose new value is unsigned-smaller than the stored word leaves the word unchanged. `wr_rejected` pulses high for exactly one cycle, with the same timing as R2. For example, 0x7FFF after 0x8000 is rejected.
- R4: A secure write whose new value equals the stored word leaves the word unchanged and is reported on `wr_rejected`, not `wr_accepted`.
- R5: The first data byte after the command is the high byte (bits 15:8) and the second is the low byte. The word index is `cmd_addr[4:1]`, and `cmd_addr[0]` has no effect on which word is addressed.
- R6: A command with any opcode other than 0x07 does not arm the guard. Data bytes that follow it change no word and produce no pulse.
- R7: A secure write whose address lies outside the first 32 bytes (`cmd_addr[9:5]` not zero) changes no word and produces no pulse.
- R8: If `sel` drops after only one data byte, no word changes and no pulse occurs. A following complete write uses only its own two bytes.
- R9: Each secure-write command produces at most one pulse, and `wr_accepted` and `wr_rejected` are never high together. Data bytes beyond the second are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears every word |
| sel | input | 1 | High while the device is selected; low ends the current command |
| cmd_vld | input | 1 | One-cycle strobe: `cmd_op` and `cmd_addr` hold a new command |
| cmd_op | input | 8 | Decoded opcode of the command |
| cmd_addr | input | 10 | Byte start address of the command |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received data byte |
| byte_data | input | 8 | Received data byte |
| rd_idx | input | 4 | Index of the word shown on `rd_data` |
| rd_data | output | 16 | Current content of word `rd_idx` (combinational) |
| wr_accepted | output | 1 | One-cycle pulse: the last complete word was stored |
| wr_rejected | output | 1 | One-cycle pulse: the last complete word was refused |

## Verification
The hardest state to reach from the ports is a word that already holds a large value, probed with candidates one step on either side of it. A write to a fresh word can never be rejected except by an equal zero, so the vector table first raises words to 0x0001, 0x8000, 0xFFFF and 0x0100. Later entries then offer those same words equal, smaller and just-larger values. The pair 0x0100 followed by 0x00FF catches a swapped byte order, and 0x8000 followed by 0x7FFF catches a signed compare. The partial-word case is followed at once by a full write to the same word, which shows that a dangling high byte does not leak into the next command.

// File: rtl/iw_pkg.sv
package iw_pkg;

    // Progress of one secure-write command through its two data bytes
    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_HI   = 2'd1,
        C_LO   = 2'd2,
        C_DONE = 2'd3
    } col_state_e;

endpackage

// File: rtl/iw_collect.sv
module iw_collect #(
    parameter int          ADDR_W    = 10,
    parameter int          BYTE_W    = 8,
    parameter int          IDX_W     = 4,
    parameter int          OP_W      = 8,
    parameter logic [7:0]  SECURE_OP = 8'h07,
    localparam int         WORD_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cmd_vld,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              word_vld,
    output logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] word_val
);
    import iw_pkg::*;

    typedef struct packed {
        col_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] hi;
    } col_t;

    col_t col_d, col_q;

    // Byte address halved gives the word address; the part above the
    // index must be zero for the command to fall in the protected area.
    logic [ADDR_W-1:0] half_addr;
    logic [ADDR_W-1:0] above_area;
    logic              in_area;
    logic              is_secure;

    always_comb begin
        half_addr  = cmd_addr >> 1;
        above_area = half_addr >> IDX_W;
        in_area    = (above_area == '0);
        is_secure  = (cmd_op == OP_W'(SECURE_OP));
    end

    always_comb begin
        col_d    = col_q;
        word_vld = 1'b0;
        word_idx = col_q.idx;
        word_val = {col_q.hi, byte_data};

        if (!sel) begin
            col_d.state = C_IDLE;
        end else if (cmd_vld) begin
            if (is_secure && in_area) begin
                col_d.state = C_HI;
                col_d.idx   = half_addr[IDX_W-1:0];
            end else begin
                col_d.state = C_IDLE;
            end
        end else if (byte_vld) begin
            case (col_q.state)
                C_HI: begin
                    col_d.hi    = byte_data;
                    col_d.state = C_LO;
                end
                C_LO: begin
                    word_vld    = 1'b1;
                    col_d.state = C_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '{state: C_IDLE, idx: '0, hi: '0};
        end else begin
            col_q <= col_d;
        end
    end

endmodule

// File: rtl/iw_judge.sv
module iw_judge #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] new_val,
    input  logic [WORD_W-1:0] cur_val,
    output logic              commit,
    output logic              acc_o,
    output logic              rej_o
);
    typedef struct packed {
        logic acc;
        logic rej;
    } res_t;

    res_t res_d, res_q;
    logic raises;

    always_comb begin
        // Unsigned magnitude compare; equality counts as no progress
        raises    = (new_val > cur_val);
        commit    = word_vld && raises;
        res_d.acc = word_vld && raises;
        res_d.rej = word_vld && !raises;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign acc_o = res_q.acc;
    assign rej_o = res_q.rej;

endmodule

// File: rtl/iw_store.sv
module iw_store #(
    parameter int NUM_WORDS = 16,
    parameter int WORD_W    = 16,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_val,
    output logic [WORD_W-1:0] cur_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                w_d = wr_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign words[g] = w_q;
    end

    assign cur_val = words[wr_idx];
    assign rd_data = words[rd_idx];

endmodule

// File: rtl/incr_word_guard.sv
module incr_word_guard #(
    parameter int         NUM_WORDS = 16,
    parameter int         BYTE_W    = 8,
    parameter int         ADDR_W    = 10,
    parameter int         OP_W      = 8,
    parameter logic [7:0] SECURE_OP = 8'h07,
    localparam int        WORD_W    = 2 * BYTE_W,
    localparam int        IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cmd_vld,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              wr_accepted,
    output logic              wr_rejected
);
    logic              word_vld;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] word_val;
    logic [WORD_W-1:0] cur_val;
    logic              commit;

    iw_collect #(
        .ADDR_W    (ADDR_W),
        .BYTE_W    (BYTE_W),
        .IDX_W     (IDX_W),
        .OP_W      (OP_W),
        .SECURE_OP (SECURE_OP)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .cmd_vld   (cmd_vld),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .word_vld  (word_vld),
        .word_idx  (word_idx),
        .word_val  (word_val)
    );

    iw_judge #(
        .WORD_W (WORD_W)
    ) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .new_val  (word_val),
        .cur_val  (cur_val),
        .commit   (commit),
        .acc_o    (wr_accepted),
        .rej_o    (wr_rejected)
    );

    iw_store #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (word_idx),
        .wr_val  (word_val),
        .cur_val (cur_val),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/iw_guard_chk.sv
module iw_guard_chk #(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              byte_vld,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [WORD_W-1:0] rd_data,
    input logic              wr_accepted,
    input logic              wr_rejected
);
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accepted && wr_rejected)); // R9

    AST_ACC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accepted |=> !wr_accepted); // R2

    AST_REJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rejected |=> !wr_rejected); // R3

    AST_WORD_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_idx) |-> (rd_data >= $past(rd_data))); // R3

    AST_PULSE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accepted || wr_rejected) |-> $past(sel && byte_vld)); // R8

    AST_REJECT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rejected && $stable(rd_idx)) |-> $stable(rd_data)); // R4

endmodule

bind incr_word_guard iw_guard_chk #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
) u_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .byte_vld    (byte_vld),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .wr_accepted (wr_accepted),
    .wr_rejected (wr_rejected)
);

// File: tb/test_incr_word_guard.sv
module test_incr_word_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel;
    logic        cmd_vld;
    logic [7:0]  cmd_op;
    logic [9:0]  cmd_addr;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic [3:0]  rd_idx;
    logic [15:0] rd_data;
    logic        wr_accepted;
    logic        wr_rejected;

    always #5 clk = ~clk;

    incr_word_guard i_incr_word_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .cmd_vld     (cmd_vld),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .wr_accepted (wr_accepted),
        .wr_rejected (wr_rejected)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // kind: 0 -> R2 (raise), 1 -> R3 (lower), 2 -> R4 (equal), 3 -> R5 (byte/index)
    typedef struct packed {
        logic [9:0]  addr;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic        exp_acc;
        logic [15:0] exp_word;
        logic [1:0]  kind;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{addr: 10'h000, hi: 8'h00, lo: 8'h01, exp_acc: 1'b1, exp_word: 16'h0001, kind: 2'd0},
        '{addr: 10'h000, hi: 8'h00, lo: 8'h01, exp_acc: 1'b0, exp_word: 16'h0001, kind: 2'd2},
        '{addr: 10'h001, hi: 8'h00, lo: 8'h00, exp_acc: 1'b0, exp_word: 16'h0001, kind: 2'd3},
        '{addr: 10'h002, hi: 8'h80, lo: 8'h00, exp_acc: 1'b1, exp_word: 16'h8000, kind: 2'd0},
        '{addr: 10'h003, hi: 8'h7F, lo: 8'hFF, exp_acc: 1'b0, exp_word: 16'h8000, kind: 2'd1},
        '{addr: 10'h01E, hi: 8'hFF, lo: 8'hFF, exp_acc: 1'b1, exp_word: 16'hFFFF, kind: 2'd0},
        '{addr: 10'h01F, hi: 8'hFF, lo: 8'hFE, exp_acc: 1'b0, exp_word: 16'hFFFF, kind: 2'd1},
        '{addr: 10'h004, hi: 8'h01, lo: 8'h00, exp_acc: 1'b1, exp_word: 16'h0100, kind: 2'd3},
        '{addr: 10'h004, hi: 8'h00, lo: 8'hFF, exp_acc: 1'b0, exp_word: 16'h0100, kind: 2'd3},
        '{addr: 10'h002, hi: 8'h80, lo: 8'h01, exp_acc: 1'b1, exp_word: 16'h8001, kind: 2'd0}
    };

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic read_word(input int i, output logic [15:0] v);
        rd_idx = 4'(i);
        #1;
        v = rd_data;
    endtask

    // One select window: a command, then nb bytes taken from bytes[31:24] down.
    // Counts pulse cycles, and records the pulses seen right after byte two.
    task automatic session(input logic [7:0] op, input logic [9:0] addr,
                           input logic [31:0] bytes, input int nb,
                           output int n_acc, output int n_rej,
                           output logic acc2, output logic rej2);
        n_acc = 0; n_rej = 0; acc2 = 1'b0; rej2 = 1'b0;
        @(negedge clk);
        sel = 1'b1; cmd_vld = 1'b1; cmd_op = op; cmd_addr = addr;
        @(negedge clk);
        cmd_vld = 1'b0;
        n_acc += int'(wr_accepted); n_rej += int'(wr_rejected);
        for (int k = 0; k < nb; k++) begin
            byte_vld  = 1'b1;
            byte_data = bytes[31 - 8*k -: 8];
            @(negedge clk);
            n_acc += int'(wr_accepted); n_rej += int'(wr_rejected);
            if (k == 1) begin
                acc2 = wr_accepted;
                rej2 = wr_rejected;
            end
        end
        byte_vld = 1'b0;
        @(negedge clk);
        n_acc += int'(wr_accepted); n_rej += int'(wr_rejected);
        sel = 1'b0;
        @(negedge clk);
        n_acc += int'(wr_accepted); n_rej += int'(wr_rejected);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int          na, nr;
        logic        a2, r2;
        logic [15:0] v;

        sel = 1'b0; cmd_vld = 1'b0; cmd_op = '0; cmd_addr = '0;
        byte_vld = 1'b0; byte_data = '0; rd_idx = '0;
        apply_reset();

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            read_word(i, v);
            chk("R1", $sformatf("word %0d after reset", i), 32'(v), 32'h0);
        end
        chk("R1", "accepted after reset", 32'(wr_accepted), 32'h0);
        chk("R1", "rejected after reset", 32'(wr_rejected), 32'h0);

        // Vector table walk
        for (int n = 0; n < NVEC; n++) begin
            session(8'h07, VEC[n].addr, {VEC[n].hi, VEC[n].lo, 16'h0}, 2, na, nr, a2, r2);
            chk(kind_tag(VEC[n].kind), $sformatf("vec %0d accepted pulse", n),
                32'(a2), 32'(VEC[n].exp_acc));
            chk(kind_tag(VEC[n].kind), $sformatf("vec %0d rejected pulse", n),
                32'(r2), 32'(!VEC[n].exp_acc));
            chk(kind_tag(VEC[n].kind), $sformatf("vec %0d pulse cycles", n),
                32'(na + nr), 32'h1);
            read_word(int'(VEC[n].addr[4:1]), v);
            chk(kind_tag(VEC[n].kind), $sformatf("vec %0d stored word", n),
                32'(v), 32'(VEC[n].exp_word));
        end

        // R6: non-secure opcode does not arm
        session(8'h02, 10'h006, 32'h1234_0000, 2, na, nr, a2, r2);
        chk("R6", "pulses after opcode 0x02", 32'(na + nr), 32'h0);
        read_word(3, v);
        chk("R6", "word 3 after opcode 0x02", 32'(v), 32'h0);

        // R7: address beyond the protected area
        session(8'h07, 10'h020, 32'hFFFF_0000, 2, na, nr, a2, r2);
        chk("R7", "pulses for address 0x020", 32'(na + nr), 32'h0);
        read_word(0, v);
        chk("R7", "word 0 after address 0x020", 32'(v), 32'h0001);

        // R8: partial word, then a clean full write to the same word
        session(8'h07, 10'h008, 32'hFF00_0000, 1, na, nr, a2, r2);
        chk("R8", "pulses for single byte", 32'(na + nr), 32'h0);
        read_word(4, v);
        chk("R8", "word 4 after single byte", 32'(v), 32'h0);
        session(8'h07, 10'h008, 32'h0005_0000, 2, na, nr, a2, r2);
        chk("R8", "accepted count after retry", 32'(na), 32'h1);
        read_word(4, v);
        chk("R8", "word 4 after retry", 32'(v), 32'h0005);

        // R9: extra bytes after the word are ignored
        session(8'h07, 10'h00A, 32'h0009_AABB, 4, na, nr, a2, r2);
        chk("R9", "accepted count with extra bytes", 32'(na), 32'h1);
        chk("R9", "rejected count with extra bytes", 32'(nr), 32'h0);
        read_word(5, v);
        chk("R9", "word 5 with extra bytes", 32'(v), 32'h0009);

        // R1: a second reset clears raised words
        apply_reset();
        read_word(15, v);
        chk("R1", "word 15 after second reset", 32'(v), 32'h0);
        read_word(1, v);
        chk("R1", "word 1 after second reset", 32'(v), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule